// File: doc/BRIEF.md
# Bootstrap Program RAM Loader

After reset this block fills the on-chip program RAM of a processor. It reads the operating-mode bits once, on the first clock after reset. It then picks one of two sources. The first source is a byte-wide external memory read through a request/ready handshake. The second is an external host that presents data with a valid strobe. Either source can be reached on port A or on port B. When the load is finished the block raises a one-cycle done pulse. The core then starts fetching at program word 0, which is the first word the loader wrote.

In memory mode the block walks a fixed window of byte addresses. In host mode the host picks, at load start, whether it sends bytes or full 32-bit words. The host can also cut the load short with a stop flag. Bytes are packed four to a word, least-significant byte first. A word is written to RAM only once all of its bytes have arrived.

Top module: `boot_pram_loader`

## Requirements
- R1: The mode bits `boot_mode[2:0]` are latched on the first clock edge after reset is released. If bit 2 is clear (modes 0 to 3), the block never asserts `ext_rd`, `ram_we` or `boot_done` until the next reset.
- R2: With bit 2 set and bit 1 clear (memory source), `ext_rd` is held high and `ext_addr` starts at 0xFFFF0000. The address advances by one only after a cycle in which `ext_ready` was high. Exactly 4096 bytes are accepted.
- R3: `port_b_sel` equals mode bit 0 as latched at load start (1 = port B). Later changes on `boot_mode` have no effect on it or on the load.
- R4: Every four accepted bytes form one word, with the first byte in bits 7:0 and the fourth in bits 31:24. The word is written with `ram_we` high in the cycle after the fourth byte is accepted. Word k goes to RAM address k.
- R5: With bits 2 and 1 set (host source) and HF1 low at load start, each cycle with `host_valid` high and `host_hf0` low accepts the byte `host_data[7:0]`. At most 4096 bytes are taken.
- R6: If HF1 is high at load start, each accepted host beat is a full 32-bit word. It is written in the next cycle, and at most 1024 words are taken. HF1 changes after the start are ignored.
- R7: `host_hf0` high during a host load ends the load. Data presented in that cycle and any partly assembled word are dropped.
- R8: `boot_done` is high for exactly one cycle, the cycle after the final unit is accepted or HF0 is seen. After it, no read, write or further done occurs until reset.
- R9: While reset is applied, `ext_rd`, `ram_we`, `boot_done` and `port_b_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 3 | Operating mode bits; bit 2 = bootstrap, bit 1 = host source, bit 0 = port B |
| ext_addr | output | 32 | External byte address |
| ext_rd | output | 1 | External read request |
| ext_data | input | 8 | External read byte |
| ext_ready | input | 1 | External byte valid for current address |
| host_valid | input | 1 | Host data valid this cycle |
| host_data | input | 32 | Host data (bits 7:0 in byte mode) |
| host_hf0 | input | 1 | Host stop flag |
| host_hf1 | input | 1 | Host width flag (1 = 32-bit) |
| ram_addr | output | RAM_AW | Program RAM word address |
| ram_wdata | output | 32 | Program RAM write data |
| ram_we | output | 1 | Program RAM write enable |
| port_b_sel | output | 1 | Selected port (1 = B) |
| boot_done | output | 1 | One-cycle load-complete pulse |

## Verification
The memory path is driven both with random ready stalls and with ready held high. The stalled run shows that the address is held during waits. The unstalled run shows that back-to-back bytes pack in the right lane order. Host loads are run in byte mode with gaps and in word mode with HF1 flipped after the start. Together these runs separate the two widths and show that the width is latched once. Early HF0 stops are applied once after a partial word and once on a cycle with valid data, so that dropped data is told apart from written data. A non-bootstrap mode confirms that the block stays silent.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = WORD_W / BYTE_W;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_START,
        ST_MEM,
        ST_HOST,
        ST_DONE,
        ST_HALT
    } ldr_state_e;

    typedef struct packed {
        logic bootstrap;
        logic from_host;
        logic port_b;
    } mode_t;

    typedef struct packed {
        logic              valid;
        logic              wide;
        logic [WORD_W-1:0] data;
    } unit_t;

    function automatic mode_t decode_mode(input logic [2:0] bits);
        mode_t m;
        m.bootstrap = bits[2];
        m.from_host = bits[1];
        m.port_b    = bits[0];
        return m;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned r;
        r = (a > b) ? a : b;
        return (r > c) ? r : c;
    endfunction

endpackage

// File: rtl/bl_sequencer.sv
module bl_sequencer
    import boot_ldr_pkg::*;
#(
    parameter logic [31:0] MEM_BASE   = 32'hFFFF_0000,
    parameter int unsigned MEM_BYTES  = 4096,
    parameter int unsigned HOST_BYTES = 4096,
    parameter int unsigned HOST_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        boot_mode,
    input  logic              ext_ready,
    input  logic [BYTE_W-1:0] ext_data,
    input  logic              host_valid,
    input  logic [WORD_W-1:0] host_data,
    input  logic              host_hf0,
    input  logic              host_hf1,
    output unit_t             unit,
    output logic              ext_rd,
    output logic [31:0]       ext_addr,
    output logic              port_b,
    output logic              done
);

    localparam int unsigned MAX_UNITS = max3(MEM_BYTES, HOST_BYTES, HOST_WORDS);
    localparam int unsigned CNT_W     = $clog2(MAX_UNITS + 1);
    localparam logic [CNT_W-1:0] MEM_LAST   = CNT_W'(MEM_BYTES - 1);
    localparam logic [CNT_W-1:0] HBYTE_LAST = CNT_W'(HOST_BYTES - 1);
    localparam logic [CNT_W-1:0] HWORD_LAST = CNT_W'(HOST_WORDS - 1);

    ldr_state_e       state;
    mode_t            mode_q;
    logic             wide_q;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] host_last;
    mode_t            mode_now;

    assign mode_now  = decode_mode(boot_mode);
    assign host_last = wide_q ? HWORD_LAST : HBYTE_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_START;
            mode_q <= '0;
            wide_q <= 1'b0;
            idx    <= '0;
        end else begin
            unique case (state)
                ST_START: begin
                    mode_q <= mode_now;
                    wide_q <= host_hf1;
                    idx    <= '0;
                    if (!mode_now.bootstrap)
                        state <= ST_HALT;
                    else if (mode_now.from_host)
                        state <= ST_HOST;
                    else
                        state <= ST_MEM;
                end
                ST_MEM: begin
                    if (ext_ready) begin
                        idx <= idx + 1'b1;
                        if (idx == MEM_LAST)
                            state <= ST_DONE;
                    end
                end
                ST_HOST: begin
                    if (host_hf0) begin
                        state <= ST_DONE;
                    end else if (host_valid) begin
                        idx <= idx + 1'b1;
                        if (idx == host_last)
                            state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_HALT;
                default: state <= ST_HALT;
            endcase
        end
    end

    always_comb begin
        unit.valid = ((state == ST_MEM) && ext_ready) ||
                     ((state == ST_HOST) && host_valid && !host_hf0);
        unit.wide  = (state == ST_HOST) && wide_q;
        unit.data  = (state == ST_MEM) ? {{(WORD_W-BYTE_W){1'b0}}, ext_data} : host_data;
    end

    assign ext_rd   = (state == ST_MEM);
    assign ext_addr = MEM_BASE + 32'(idx);
    assign port_b   = mode_q.port_b;
    assign done     = (state == ST_DONE);

endmodule

// File: rtl/bl_word_packer.sv
module bl_word_packer
    import boot_ldr_pkg::*;
#(
    parameter int unsigned RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  unit_t             unit,
    output logic              we,
    output logic [RAM_AW-1:0] waddr,
    output logic [WORD_W-1:0] wdata
);

    logic [LANES-1:0][BYTE_W-1:0] acc;
    logic [LANES-1:0][BYTE_W-1:0] assembled;
    logic [LANE_W-1:0]            lane;
    logic [RAM_AW-1:0]            next_addr;
    logic                         last_lane;

    assign last_lane = (lane == LANE_W'(LANES - 1));

    always_comb begin
        assembled       = acc;
        assembled[lane] = unit.data[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            lane      <= '0;
            we        <= 1'b0;
            waddr     <= '0;
            wdata     <= '0;
            next_addr <= '0;
        end else begin
            we <= 1'b0;
            if (unit.valid) begin
                if (unit.wide) begin
                    we        <= 1'b1;
                    wdata     <= unit.data;
                    waddr     <= next_addr;
                    next_addr <= next_addr + 1'b1;
                end else begin
                    acc[lane] <= unit.data[BYTE_W-1:0];
                    if (last_lane) begin
                        we        <= 1'b1;
                        wdata     <= assembled;
                        waddr     <= next_addr;
                        next_addr <= next_addr + 1'b1;
                        lane      <= '0;
                    end else begin
                        lane <= lane + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/boot_pram_loader.sv
module boot_pram_loader
    import boot_ldr_pkg::*;
#(
    parameter logic [31:0] MEM_BASE   = 32'hFFFF_0000,
    parameter int unsigned MEM_BYTES  = 4096,
    parameter int unsigned HOST_BYTES = 4096,
    parameter int unsigned HOST_WORDS = 1024,
    parameter int unsigned RAM_WORDS  = 1024,
    localparam int unsigned RAM_AW    = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        boot_mode,
    output logic [31:0]       ext_addr,
    output logic              ext_rd,
    input  logic [7:0]        ext_data,
    input  logic              ext_ready,
    input  logic              host_valid,
    input  logic [31:0]       host_data,
    input  logic              host_hf0,
    input  logic              host_hf1,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [31:0]       ram_wdata,
    output logic              ram_we,
    output logic              port_b_sel,
    output logic              boot_done
);

    unit_t unit;

    bl_sequencer #(
        .MEM_BASE  (MEM_BASE),
        .MEM_BYTES (MEM_BYTES),
        .HOST_BYTES(HOST_BYTES),
        .HOST_WORDS(HOST_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .boot_mode (boot_mode),
        .ext_ready (ext_ready),
        .ext_data  (ext_data),
        .host_valid(host_valid),
        .host_data (host_data),
        .host_hf0  (host_hf0),
        .host_hf1  (host_hf1),
        .unit      (unit),
        .ext_rd    (ext_rd),
        .ext_addr  (ext_addr),
        .port_b    (port_b_sel),
        .done      (boot_done)
    );

    bl_word_packer #(
        .RAM_AW(RAM_AW)
    ) u_pack (
        .clk  (clk),
        .rst  (rst),
        .unit (unit),
        .we   (ram_we),
        .waddr(ram_addr),
        .wdata(ram_wdata)
    );

endmodule

// File: rtl/bl_loader_checker.sv
module bl_loader_checker #(
    parameter int unsigned RAM_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       ext_addr,
    input logic              ext_rd,
    input logic              ext_ready,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_we,
    input logic              port_b_sel,
    input logic              boot_done
);

    logic [RAM_AW-1:0] wr_seen = '0;
    logic              rst_d   = 1'b0;

    always @(posedge clk) begin
        rst_d <= rst;
        if (rst) wr_seen <= '0;
        else if (ram_we) wr_seen <= wr_seen + 1'b1;
    end

    // R9: outputs are quiet after an edge taken in reset
    always @(posedge clk) begin
        if (rst_d && rst)
            assert_reset_quiet_R9: assert (!ext_rd && !ram_we && !boot_done && !port_b_sel);
    end

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (ext_rd && !ext_ready) |=> (ext_addr == $past(ext_addr)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ext_rd && ext_ready) |=> (!ext_rd || ext_addr == $past(ext_addr) + 32'd1));

    assert_port_held_R3: assert property (@(posedge clk) disable iff (rst)
        (ext_rd && $past(ext_rd)) |-> $stable(port_b_sel));

    assert_write_order_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr == wr_seen));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> !boot_done);

    assert_quiet_after_R8: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> (!ext_rd && !ram_we));

endmodule

bind boot_pram_loader bl_loader_checker #(.RAM_AW(RAM_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_addr  (ext_addr),
    .ext_rd    (ext_rd),
    .ext_ready (ext_ready),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .port_b_sel(port_b_sel),
    .boot_done (boot_done)
);

// File: tb/test_boot_pram_loader.sv
`timescale 1ns/1ps
module test_boot_pram_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  boot_mode = 3'b000;
    logic [31:0] ext_addr;
    logic        ext_rd;
    logic [7:0]  ext_data;
    logic        ext_ready = 1'b0;
    logic        host_valid = 1'b0;
    logic [31:0] host_data = '0;
    logic        host_hf0 = 1'b0;
    logic        host_hf1 = 1'b0;
    logic [9:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic        ram_we;
    logic        port_b_sel;
    logic        boot_done;

    always #4 clk = ~clk;

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return 8'(a * 7 + (a >> 8) + 8'h5A);
    endfunction
    assign ext_data = byte_at(ext_addr);

    boot_pram_loader i_boot_pram_loader (
        .clk(clk), .rst(rst), .boot_mode(boot_mode),
        .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_data(ext_data), .ext_ready(ext_ready),
        .host_valid(host_valid), .host_data(host_data),
        .host_hf0(host_hf0), .host_hf1(host_hf1),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .port_b_sel(port_b_sel), .boot_done(boot_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R4";

    // behavioural reference
    int         m_phase = 0;   // 0 start, 1 mem, 2 host, 3 done, 4 halt
    bit         m_port = 0, m_wide = 0;
    int         m_idx = 0, m_wcnt = 0;
    logic [7:0] m_q[$];
    bit         e_we = 0;
    logic [9:0] e_addr = '0;
    logic [31:0] e_data = '0;
    int         n_done = 0;

    task automatic emit(input logic [31:0] w);
        e_we = 1; e_data = w; e_addr = 10'(m_wcnt); m_wcnt++;
    endtask

    task automatic take_byte(input logic [7:0] b);
        m_q.push_back(b);
        if (m_q.size() == 4) begin
            emit({m_q[3], m_q[2], m_q[1], m_q[0]});
            m_q.delete();
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_phase = 0; m_port = 0; m_idx = 0; m_wcnt = 0; e_we = 0; m_q.delete();
        end else begin
            e_we = 0;
            case (m_phase)
                0: if (!boot_mode[2]) m_phase = 4;
                   else begin
                       m_port = boot_mode[0]; m_wide = host_hf1; m_idx = 0;
                       m_phase = boot_mode[1] ? 2 : 1;
                   end
                1: if (ext_ready) begin
                       take_byte(ext_data); m_idx++;
                       if (m_idx == 4096) m_phase = 3;
                   end
                2: if (host_hf0) m_phase = 3;
                   else if (host_valid) begin
                       if (m_wide) emit(host_data); else take_byte(host_data[7:0]);
                       m_idx++;
                       if (m_idx == (m_wide ? 1024 : 4096)) m_phase = 3;
                   end
                3: m_phase = 4;
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            string rq_rd, rq_w;
            rq_rd = rst ? "R9" : (cur_req == "R1") ? "R1" : "R2";
            rq_w  = rst ? "R9" : cur_req;
            chk(ext_rd === (m_phase == 1), rq_rd, "ext_rd", 32'(ext_rd), 32'(m_phase == 1));
            if (m_phase == 1)
                chk(ext_addr === 32'hFFFF0000 + 32'(m_idx), "R2", "ext_addr", ext_addr,
                    32'hFFFF0000 + 32'(m_idx));
            chk(port_b_sel === m_port, rst ? "R9" : "R3", "port_b_sel",
                32'(port_b_sel), 32'(m_port));
            chk(ram_we === e_we, rq_w, "ram_we", 32'(ram_we), 32'(e_we));
            if (e_we) begin
                chk(ram_addr === e_addr, rq_w, "ram_addr", 32'(ram_addr), 32'(e_addr));
                chk(ram_wdata === e_data, rq_w, "ram_wdata", ram_wdata, e_data);
            end
            chk(boot_done === (m_phase == 3), rst ? "R9" : "R8", "boot_done",
                32'(boot_done), 32'(m_phase == 3));
            if (boot_done === 1'b1) n_done++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_reset(input logic [2:0] mode, input bit hf1);
        @(posedge clk); #2;
        rst = 1; boot_mode = mode; host_hf1 = hf1; host_hf0 = 0;
        host_valid = 0; ext_ready = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        n_done = 0;
    endtask

    task automatic finish_test(input string req, input int exp_done, input int exp_words);
        repeat (6) @(posedge clk);
        @(negedge clk); #1;
        chk(n_done == exp_done, "R8", {req, " done pulses"}, 32'(n_done), 32'(exp_done));
        chk(m_wcnt == exp_words, req, "words written", 32'(m_wcnt), 32'(exp_words));
    endtask

    // R2/R4 memory source
    task automatic run_mem(input logic [2:0] mode, input int stall_pct, input bit poke_mode);
        int n;
        cur_req = "R4";
        do_reset(mode, 0);
        n = 0;
        while (m_phase != 4) begin
            @(posedge clk); #2;
            ext_ready = ($urandom % 100) >= stall_pct;
            n++;
            if (poke_mode && n == 200) boot_mode = 3'b110; // R3: ignored after start
        end
        ext_ready = 0;
        finish_test("R4", 1, 1024);
    endtask

    // R5/R6/R7 host source
    task automatic run_host(input logic [2:0] mode, input bit hf1, input int stop_after,
                            input int gap_pct, input string req);
        int sent;
        cur_req = req;
        do_reset(mode, hf1);
        sent = 0;
        while (m_phase != 4) begin
            @(posedge clk); #2;
            if (sent == 8) host_hf1 = ~hf1; // R6: width latched at start
            host_valid = ($urandom % 100) >= gap_pct;
            host_data  = $urandom;
            if (stop_after >= 0 && sent >= stop_after) begin
                host_hf0 = 1; host_valid = 1;
            end
            if (host_valid && !host_hf0) sent++;
        end
        host_valid = 0; host_hf0 = 0;
    endtask

    initial begin
        // R9 reset state checked by the per-cycle compare while rst is high
        run_mem(3'b100, 30, 0);              // R2 R4 port A with stalls
        run_mem(3'b101, 0, 1);               // R3 port B, mode poked mid-load
        run_host(3'b110, 0, -1, 20, "R5");   // R5 full byte load
        finish_test("R5", 1, 1024);
        run_host(3'b111, 1, -1, 10, "R6");   // R6 full word load, HF1 flipped
        finish_test("R6", 1, 1024);
        run_host(3'b110, 0, 10, 0, "R7");    // R7 stop after 10 bytes: 2 words
        finish_test("R7", 1, 2);
        run_host(3'b111, 1, 5, 0, "R7");     // R7 stop with valid data present
        finish_test("R7", 1, 5);
        cur_req = "R1";                      // R1 non-bootstrap mode stays silent
        do_reset(3'b010, 0);
        repeat (20) begin
            @(posedge clk); #2; ext_ready = 1; host_valid = 1;
        end
        finish_test("R1", 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule